// File: doc/BRIEF.md
# Dual-Lane Spectral Point Multiplier

This block multiplies an image spectrum by a filter transfer function element by element. After a start pulse it walks every location of a 256×256 complex matrix. The image spectrum and the filter coefficients sit in two separate dual-port memories and are read at the same address. Each memory port feeds its own multiply lane, so two complex products come out every clock. Each product is written to a result memory at the address it was read from.

A linear address holds the row in its upper eight bits and the column in its lower eight. Lane A takes the even addresses and lane B the odd address directly after. A full pass therefore issues reads for 32768 cycles and then drains the pipeline. The filter coefficients are signed fractions with 31 fraction bits. Each 65-bit sum of products is shifted right arithmetically by 31 and clipped to the 32-bit signed range before it is written.

Top module: `spec_cmul_top`

## Requirements
- R1: From the clock edge that samples `start` in idle, the block issues one read pair per clock for 32768 clocks. Lane A reads address 2p and lane B reads 2p+1 at pair p = 0, 1, 2, and so on. The address is row×256 + column.
- R2: Memory read data is taken exactly one clock after the read address is presented.
- R3: The written real part is floor((Ir·Hr − Ii·Hi) / 2^31), clipped, where all operands are signed 32-bit two's complement.
- R4: The written imaginary part is floor((Ir·Hi + Ii·Hr) / 2^31), clipped.
- R5: A result above 2^31−1 is written as 0x7FFFFFFF and a result below −2^31 is written as 0x80000000. The result never wraps.
- R6: The result for the reads issued at the edge that samples pair p is written four clocks later, with the write address equal to the read address.
- R7: Both write enables are high in exactly the clocks that carry valid results, and they are always high together.
- R8: `done` is high for one clock, in the clock after the final write of a pass, and only once per pass.
- R9: A `start` pulse that arrives while a pass is issuing or draining is ignored. The pass order and timing stay unchanged.
- R10: During and after reset, with no pass running, no write enable and no `done` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a pass when idle |
| done | output | 1 | One-clock pulse after the last write |
| a_rd_addr | output | 16 | Lane A read address (even) |
| a_img_re | input | 32 | Lane A image spectrum, real |
| a_img_im | input | 32 | Lane A image spectrum, imaginary |
| a_flt_re | input | 32 | Lane A filter coefficient, real |
| a_flt_im | input | 32 | Lane A filter coefficient, imaginary |
| a_wr_en | output | 1 | Lane A result write enable |
| a_wr_addr | output | 16 | Lane A result address |
| a_wr_re | output | 32 | Lane A result, real |
| a_wr_im | output | 32 | Lane A result, imaginary |
| b_rd_addr | output | 16 | Lane B read address (odd) |
| b_img_re | input | 32 | Lane B image spectrum, real |
| b_img_im | input | 32 | Lane B image spectrum, imaginary |
| b_flt_re | input | 32 | Lane B filter coefficient, real |
| b_flt_im | input | 32 | Lane B filter coefficient, imaginary |
| b_wr_en | output | 1 | Lane B result write enable |
| b_wr_addr | output | 16 | Lane B result address |
| b_wr_re | output | 32 | Lane B result, real |
| b_wr_im | output | 32 | Lane B result, imaginary |

## Verification
Checks that run on every clock cover the local rules:
- the two lanes write together, lane A's write address is even and lane B's is the next one up;
- read addresses advance by two during a pass;
- a pulse on `start` mid-pass does not disturb the scan;
- `done` is a single clock wide and directly follows a write;
- a clipped result keeps the sign of its sum;
- nothing is written while idle.

The arithmetic and the timing can only be shown by the bench's scenarios, which compare all 65536 results of each pass against the expected products. Those scenarios cover:
- the exact four-clock latency from read to write;
- the full coverage and order of addresses;
- the floor rounding;
- clipping in both directions, using random spectra, an all-ones filter, a purely imaginary filter and a pass built for saturation.

// File: rtl/spec_cmul_pkg.sv
package spec_cmul_pkg;

    typedef enum logic [1:0] {
        SC_IDLE  = 2'd0,
        SC_ISSUE = 2'd1,
        SC_DRAIN = 2'd2
    } scan_state_e;

endpackage

// File: rtl/spec_cmul_scan.sv
module spec_cmul_scan
    import spec_cmul_pkg::*;
#(
    parameter int PAIR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wb_last,
    output logic              issue_vld,
    output logic [PAIR_W-1:0] issue_pair,
    output logic              issue_last,
    output logic              busy,
    output logic              done
);

    localparam logic [PAIR_W-1:0] LAST_PAIR = {PAIR_W{1'b1}};

    typedef struct packed {
        scan_state_e       st;
        logic [PAIR_W-1:0] pair;
        logic              vld;
        logic              last;
        logic              done;
    } scan_st_t;

    scan_st_t q, d;

    always_comb begin
        d      = q;
        d.vld  = 1'b0;
        d.done = 1'b0;
        case (q.st)
            SC_IDLE: begin
                if (start) begin
                    d.st   = SC_ISSUE;
                    d.pair = '0;
                    d.vld  = 1'b1;
                end
            end
            SC_ISSUE: begin
                if (q.pair == LAST_PAIR) begin
                    d.st = SC_DRAIN;
                end else begin
                    d.pair = q.pair + 1'b1;
                    d.vld  = 1'b1;
                end
            end
            SC_DRAIN: begin
                if (wb_last) begin
                    d.st   = SC_IDLE;
                    d.done = 1'b1;
                end
            end
            default: d.st = SC_IDLE;
        endcase
        d.last = d.vld && (d.pair == LAST_PAIR);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign issue_vld  = q.vld;
    assign issue_pair = q.pair;
    assign issue_last = q.last;
    assign busy       = (q.st != SC_IDLE);
    assign done       = q.done;

    // A start seen mid-issue must not reset the pair counter
    assert_start_ignored_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SC_ISSUE && start && q.pair != LAST_PAIR) |=> (q.pair == $past(q.pair) + 1'b1))
        else $error("start restarted a running pass");

    assert_drain_no_issue_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SC_DRAIN && start) |=> !q.vld)
        else $error("issue resumed while draining");

endmodule

// File: rtl/spec_cmul_lane.sv
module spec_cmul_lane #(
    parameter int DW     = 32,
    parameter int AW     = 16,
    parameter int FRAC   = 31,
    parameter int RD_LAT = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic          in_last,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] img_re,
    input  logic [DW-1:0] img_im,
    input  logic [DW-1:0] flt_re,
    input  logic [DW-1:0] flt_im,
    output logic          out_vld,
    output logic          out_last,
    output logic [AW-1:0] out_addr,
    output logic [DW-1:0] out_re,
    output logic [DW-1:0] out_im
);

    localparam int PW = 2 * DW;
    localparam int SW = PW + 1;
    localparam int T  = RD_LAT - 1;
    localparam logic signed [SW-1:0] SAT_HI = {{(SW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [SW-1:0] SAT_LO = {{(SW-DW+1){1'b1}}, {(DW-1){1'b0}}};

    typedef struct packed {
        logic [RD_LAT-1:0]         t_vld;
        logic [RD_LAT-1:0]         t_last;
        logic [RD_LAT-1:0][AW-1:0] t_addr;
        logic                      m_vld;
        logic                      m_last;
        logic [AW-1:0]             m_addr;
        logic [PW-1:0]             p_rr;
        logic [PW-1:0]             p_ii;
        logic [PW-1:0]             p_ri;
        logic [PW-1:0]             p_ir;
        logic                      s_vld;
        logic                      s_last;
        logic [AW-1:0]             s_addr;
        logic [SW-1:0]             s_re;
        logic [SW-1:0]             s_im;
        logic                      o_vld;
        logic                      o_last;
        logic [AW-1:0]             o_addr;
        logic [DW-1:0]             o_re;
        logic [DW-1:0]             o_im;
    } lane_st_t;

    lane_st_t q, d;

    function automatic logic [DW-1:0] clip(input logic signed [SW-1:0] v);
        if (v > SAT_HI)      return SAT_HI[DW-1:0];
        else if (v < SAT_LO) return SAT_LO[DW-1:0];
        else                 return v[DW-1:0];
    endfunction

    always_comb begin
        logic signed [PW-1:0] ir, ii, hr, hi;
        logic signed [SW-1:0] sr, si;
        d = q;
        // tag delay matching the memory read latency
        d.t_vld[0]  = in_vld;
        d.t_last[0] = in_last;
        d.t_addr[0] = in_addr;
        for (int i = 1; i < RD_LAT; i++) begin
            d.t_vld[i]  = q.t_vld[i-1];
            d.t_last[i] = q.t_last[i-1];
            d.t_addr[i] = q.t_addr[i-1];
        end
        // stage 1: four products
        ir = {{DW{img_re[DW-1]}}, img_re};
        ii = {{DW{img_im[DW-1]}}, img_im};
        hr = {{DW{flt_re[DW-1]}}, flt_re};
        hi = {{DW{flt_im[DW-1]}}, flt_im};
        d.m_vld  = q.t_vld[T];
        d.m_last = q.t_last[T];
        d.m_addr = q.t_addr[T];
        d.p_rr   = ir * hr;
        d.p_ii   = ii * hi;
        d.p_ri   = ir * hi;
        d.p_ir   = ii * hr;
        // stage 2: subtract and add at full width
        d.s_vld  = q.m_vld;
        d.s_last = q.m_last;
        d.s_addr = q.m_addr;
        d.s_re   = {q.p_rr[PW-1], q.p_rr} - {q.p_ii[PW-1], q.p_ii};
        d.s_im   = {q.p_ri[PW-1], q.p_ri} + {q.p_ir[PW-1], q.p_ir};
        // stage 3: fractional shift and clip
        sr = $signed(q.s_re) >>> FRAC;
        si = $signed(q.s_im) >>> FRAC;
        d.o_vld  = q.s_vld;
        d.o_last = q.s_last;
        d.o_addr = q.s_addr;
        d.o_re   = clip(sr);
        d.o_im   = clip(si);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_vld  = q.o_vld;
    assign out_last = q.o_last;
    assign out_addr = q.o_addr;
    assign out_re   = q.o_re;
    assign out_im   = q.o_im;

    // Clipping never flips the sign of the full-width sum
    assert_sign_keep_re_R5 : assert property (@(posedge clk) disable iff (!rst_n)
        q.s_vld |=> (q.o_re[DW-1] == $past(q.s_re[SW-1])))
        else $error("real result wrapped");

    assert_sign_keep_im_R5 : assert property (@(posedge clk) disable iff (!rst_n)
        q.s_vld |=> (q.o_im[DW-1] == $past(q.s_im[SW-1])))
        else $error("imaginary result wrapped");

    assert_addr_follow_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        q.s_vld |=> (q.o_addr == $past(q.s_addr)))
        else $error("write address lost alignment");

endmodule

// File: rtl/spec_cmul_top.sv
module spec_cmul_top #(
    parameter int DW     = 32,
    parameter int ROW_W  = 8,
    parameter int COL_W  = 8,
    parameter int FRAC   = 31,
    parameter int RD_LAT = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    output logic                   done,
    output logic [ROW_W+COL_W-1:0] a_rd_addr,
    input  logic [DW-1:0]          a_img_re,
    input  logic [DW-1:0]          a_img_im,
    input  logic [DW-1:0]          a_flt_re,
    input  logic [DW-1:0]          a_flt_im,
    output logic                   a_wr_en,
    output logic [ROW_W+COL_W-1:0] a_wr_addr,
    output logic [DW-1:0]          a_wr_re,
    output logic [DW-1:0]          a_wr_im,
    output logic [ROW_W+COL_W-1:0] b_rd_addr,
    input  logic [DW-1:0]          b_img_re,
    input  logic [DW-1:0]          b_img_im,
    input  logic [DW-1:0]          b_flt_re,
    input  logic [DW-1:0]          b_flt_im,
    output logic                   b_wr_en,
    output logic [ROW_W+COL_W-1:0] b_wr_addr,
    output logic [DW-1:0]          b_wr_re,
    output logic [DW-1:0]          b_wr_im
);

    localparam int AW     = ROW_W + COL_W;
    localparam int PAIR_W = AW - 1;
    localparam int LANES  = 2;

    logic              issue_vld, issue_last, busy, wb_last;
    logic [PAIR_W-1:0] issue_pair;

    logic [LANES-1:0][DW-1:0] img_re, img_im, flt_re, flt_im, res_re, res_im;
    logic [LANES-1:0][AW-1:0] rd_addr, res_addr;
    logic [LANES-1:0]         res_vld, res_last;

    assign img_re = {b_img_re, a_img_re};
    assign img_im = {b_img_im, a_img_im};
    assign flt_re = {b_flt_re, a_flt_re};
    assign flt_im = {b_flt_im, a_flt_im};

    spec_cmul_scan #(.PAIR_W(PAIR_W)) i_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .wb_last    (wb_last),
        .issue_vld  (issue_vld),
        .issue_pair (issue_pair),
        .issue_last (issue_last),
        .busy       (busy),
        .done       (done)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign rd_addr[g] = {issue_pair, 1'(g)};
        spec_cmul_lane #(
            .DW(DW), .AW(AW), .FRAC(FRAC), .RD_LAT(RD_LAT)
        ) i_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_vld   (issue_vld),
            .in_last  (issue_last),
            .in_addr  (rd_addr[g]),
            .img_re   (img_re[g]),
            .img_im   (img_im[g]),
            .flt_re   (flt_re[g]),
            .flt_im   (flt_im[g]),
            .out_vld  (res_vld[g]),
            .out_last (res_last[g]),
            .out_addr (res_addr[g]),
            .out_re   (res_re[g]),
            .out_im   (res_im[g])
        );
    end

    assign wb_last = &(res_vld & res_last);

    assign a_rd_addr = rd_addr[0];
    assign b_rd_addr = rd_addr[1];
    assign a_wr_en   = res_vld[0];
    assign a_wr_addr = res_addr[0];
    assign a_wr_re   = res_re[0];
    assign a_wr_im   = res_im[0];
    assign b_wr_en   = res_vld[1];
    assign b_wr_addr = res_addr[1];
    assign b_wr_re   = res_re[1];
    assign b_wr_im   = res_im[1];

    assert_lane_parity_R1 : assert property (@(posedge clk) disable iff (!rst_n)
        a_wr_en |-> (!a_wr_addr[0] && b_wr_addr == a_wr_addr + 1'b1))
        else $error("lane addresses not an even/odd pair");

    assert_rd_step_R1 : assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && $past(issue_vld)) |-> (a_rd_addr == $past(a_rd_addr) + 2'd2))
        else $error("read address skipped");

    assert_lanes_paired_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        a_wr_en == b_wr_en)
        else $error("lane write enables differ");

    assert_quiet_idle_R10 : assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!a_wr_en && !b_wr_en))
        else $error("write while idle");

    assert_done_pulse_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("done wider than one clock");

    assert_done_after_write_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(a_wr_en))
        else $error("done without a preceding write");

endmodule

// File: tb/test_spec_cmul_top.sv
module test_spec_cmul_top;

    localparam int PAIRS    = 32768;
    localparam int LAT      = 4;
    localparam int LAST_N   = PAIRS - 1 + LAT;
    localparam int WATCHDOG = 190000;
    localparam logic signed [64:0] HI = 65'sh0_7FFF_FFFF;
    localparam logic signed [64:0] LO = -65'sh0_8000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        done;
    logic [15:0] a_rd_addr, b_rd_addr, a_wr_addr, b_wr_addr;
    logic [31:0] a_img_re, a_img_im, a_flt_re, a_flt_im;
    logic [31:0] b_img_re, b_img_im, b_flt_re, b_flt_im;
    logic        a_wr_en, b_wr_en;
    logic [31:0] a_wr_re, a_wr_im, b_wr_re, b_wr_im;

    int errors = 0;
    int checks = 0;
    int mode   = 0;

    always #5 clk = ~clk;

    spec_cmul_top i_spec_cmul_top (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done),
        .a_rd_addr(a_rd_addr), .a_img_re(a_img_re), .a_img_im(a_img_im),
        .a_flt_re(a_flt_re), .a_flt_im(a_flt_im), .a_wr_en(a_wr_en),
        .a_wr_addr(a_wr_addr), .a_wr_re(a_wr_re), .a_wr_im(a_wr_im),
        .b_rd_addr(b_rd_addr), .b_img_re(b_img_re), .b_img_im(b_img_im),
        .b_flt_re(b_flt_re), .b_flt_im(b_flt_im), .b_wr_en(b_wr_en),
        .b_wr_addr(b_wr_addr), .b_wr_re(b_wr_re), .b_wr_im(b_wr_im)
    );

    function automatic logic [31:0] mix(input logic [31:0] x);
        logic [31:0] y;
        y = x * 32'h9E37_79B1;
        y = y ^ (y >> 15);
        y = y * 32'h85EB_CA6B;
        return y ^ (y >> 13);
    endfunction

    // which: 0 img re, 1 img im, 2 filter re, 3 filter im
    function automatic logic [31:0] gen(input int m, input int which, input logic [15:0] ad);
        logic [31:0] rnd;
        rnd = mix({which[3:0], m[3:0], 8'h5A, ad});
        case (m)
            1: return (which == 2) ? 32'h7FFF_FFFF : (which == 3) ? 32'h0 : rnd;
            2: return (which == 2) ? 32'h0 : (which == 3) ? 32'h7FFF_FFFF : rnd;
            3: begin
                if (which == 2) return 32'h8000_0000;
                if (which == 3) return 32'h7FFF_FFFF;
                return ad[0] ? 32'h7FFF_FFFF : 32'h8000_0000;
            end
            default: return rnd;
        endcase
    endfunction

    function automatic logic [31:0] ref_part(input logic [31:0] x1, y1, x2, y2, input bit sub);
        logic signed [64:0] a, b, s;
        a = $signed({{33{x1[31]}}, x1}) * $signed({{33{y1[31]}}, y1});
        b = $signed({{33{x2[31]}}, x2}) * $signed({{33{y2[31]}}, y2});
        s = sub ? (a - b) : (a + b);
        s = s >>> 31;
        if (s > HI) return 32'h7FFF_FFFF;
        if (s < LO) return 32'h8000_0000;
        return s[31:0];
    endfunction

    // behavioural memories, one clock read latency (R2)
    always @(posedge clk) begin
        a_img_re <= gen(mode, 0, a_rd_addr);
        a_img_im <= gen(mode, 1, a_rd_addr);
        a_flt_re <= gen(mode, 2, a_rd_addr);
        a_flt_im <= gen(mode, 3, a_rd_addr);
        b_img_re <= gen(mode, 0, b_rd_addr);
        b_img_im <= gen(mode, 1, b_rd_addr);
        b_flt_re <= gen(mode, 2, b_rd_addr);
        b_flt_im <= gen(mode, 3, b_rd_addr);
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            if (errors < 20)
                $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_result(input logic [15:0] ad, input logic [31:0] re, input logic [31:0] im);
        logic [31:0] er, ei;
        er = ref_part(gen(mode,0,ad), gen(mode,2,ad), gen(mode,1,ad), gen(mode,3,ad), 1'b1);
        ei = ref_part(gen(mode,0,ad), gen(mode,3,ad), gen(mode,1,ad), gen(mode,2,ad), 1'b0);
        check(re === er, (mode == 3) ? "R5" : "R3", "real", re, er);
        check(im === ei, (mode == 3) ? "R5" : "R4", "imag", im, ei);
    endtask

    task automatic run_pass(input int m, input bit poke);
        mode = m;
        @(negedge clk);
        start = 1'b1;
        for (int n = 0; n <= LAST_N + 4; n++) begin
            bit exp_w;
            @(negedge clk);
            if (n == 0) start = 1'b0;
            exp_w = (n >= LAT) && (n <= LAST_N);
            check(a_wr_en === exp_w, "R7", "a_wr_en", 32'(a_wr_en), 32'(exp_w));
            check(b_wr_en === exp_w, "R7", "b_wr_en", 32'(b_wr_en), 32'(exp_w));
            check(done === (n == LAST_N + 1), "R8", "done", 32'(done), 32'(n == LAST_N + 1));
            if (exp_w) begin
                logic [15:0] ea;
                ea = 16'((n - LAT) * 2);
                // R1 ordering and R6 alignment
                check(a_wr_addr === ea, "R6", "a_wr_addr", 32'(a_wr_addr), 32'(ea));
                check(b_wr_addr === ea + 16'd1, "R1", "b_wr_addr", 32'(b_wr_addr), 32'(ea + 16'd1));
                check_result(ea, a_wr_re, a_wr_im);
                check_result(ea + 16'd1, b_wr_re, b_wr_im);
            end
            // R9: stray start while issuing and while draining
            if (poke) begin
                if (n == 100 || n == LAST_N - 1) start = 1'b1;
                if (n == 101 || n == LAST_N)     start = 1'b0;
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(a_wr_en === 1'b0 && b_wr_en === 1'b0, "R10", "wr_en in reset", 32'(a_wr_en), 32'd0);
        check(done === 1'b0, "R10", "done in reset", 32'(done), 32'd0);
        rst_n = 1'b1;
        repeat (4) begin
            @(negedge clk);
            check(a_wr_en === 1'b0 && b_wr_en === 1'b0, "R10", "wr_en idle", 32'(a_wr_en), 32'd0);
            check(done === 1'b0, "R10", "done idle", 32'(done), 32'd0);
        end
        run_pass(0, 1'b1);   // random spectra, with ignored start pulses
        run_pass(1, 1'b0);   // all-ones filter
        run_pass(2, 1'b0);   // purely imaginary filter
        run_pass(3, 1'b0);   // saturation in both directions
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule